// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block produces the digital timing for a 64-pixel linear image sensor that is read out serially, one pixel per readout clock. A start input sampled on a rising clock edge begins a readout and a new integration period. The sequencer then gives the output multiplexer a pixel index from 1 to 64 with a valid flag, drives two sample/hold lines, and drives an active-low pulse that clears the integration capacitors. The sample/hold lines are high for hold. One line serves pixels 1 to 63 and the other serves pixel 64.

The hold line for pixel 64 follows the main hold line one clock later, in both directions. Because of this, the last pixel can be presented in the 64th clock without a 65th. A start that arrives part way through a readout sends the index back to pixel 1 and leaves the held values alone. When no start comes after pixel 64, the sequencer enters a tracking state: the multiplexer sits on pixel 1, neither hold line is asserted, and the output follows that pixel's live value.

The integration clear is produced by a register clocked on the falling edge of the readout clock, so the pulse is one full clock long and has no glitches.

Top module: `lsr_readout_seq`

## Requirements
- R1: While rst_n is low: pix_idx is 0, pix_valid is 0, hold_main and hold_last are 0 (sample), and integ_rst_n is 0 (clear active).
- R2: A start sampled high at a rising edge from the idle or tracking state presents pix_idx 1 after that edge. With start low, pix_idx then rises by one per clock up to 64.
- R3: hold_main becomes 1 at the edge that samples a fresh start. hold_last always equals the value hold_main had one clock earlier.
- R4: hold_main returns to 0 at the edge where pix_idx advances from 63 to 64. hold_last returns to 0 one clock later.
- R5: After a fresh start sampled at rising edge E0, integ_rst_n is low from the 2nd to the 3rd falling edge after E0 and high at every other falling edge after reset.
- R6: A start sampled while pix_idx is between 1 and 63 returns pix_idx to 1. It leaves both hold lines at 1 and produces no integration clear pulse.
- R7: A start sampled while pix_idx is 64 is a fresh start. hold_main goes to 1, hold_last goes to 1 one clock later, and a clear pulse follows as in R5.
- R8: At the edge after pix_idx 64, if start is low, the block enters tracking: pix_idx is 1, pix_valid is 0, and hold_main is 0. It stays in tracking until the next start.
- R9: A start held high during reset has no effect. After release with start low, the block remains idle (pix_idx 0, pix_valid 0).
- R10: pix_valid is 1 exactly while a readout presents a pixel index from 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; rising edges sample start and advance the index |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Readout start request, sampled on rising edges |
| pix_idx | output | IDX_W (7) | Pixel index for the output multiplexer; 0 means idle |
| pix_valid | output | 1 | High while a pixel of the current readout is presented |
| hold_main | output | 1 | Sample/hold control for pixels 1 to 63, 1 = hold |
| hold_last | output | 1 | Sample/hold control for pixel 64, 1 = hold |
| integ_rst_n | output | 1 | Active-low integration capacitor clear, changes on falling edges |

## Verification
The bench issues a second start at every index from 1 to 64. This separates the restart case from the boundary at 64, where a start is a fresh readout. A design that handles index 63 or 64 wrongly would either drop the held values or fail to re-sample. The integration clear is checked on the falling-edge timeline, and restarts inside the pulse window are included. A design that pulsed on a restart, or that timed the pulse to the wrong edge, shows a low level in the wrong sample. The bench also runs past pixel 64 with no start, which catches a design that wraps the index or leaves a hold line set in the tracking state.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_TRACK = 2'd2
  } seq_state_e;

  // Index shown to the multiplexer for a given state and counter value.
  function automatic int shown_index(seq_state_e st, int cnt);
    int r;
    case (st)
      SEQ_READ:  r = cnt;
      SEQ_TRACK: r = 1;
      default:   r = 0;
    endcase
    return r;
  endfunction

  // A start during an unfinished readout is a restart rather than a new cycle.
  function automatic bit is_restart(bit start, seq_state_e st, int cnt, int n_pix);
    return start && (st == SEQ_READ) && (cnt < n_pix);
  endfunction

  // Counter value that follows the current one when no start arrives.
  function automatic int next_count(int cnt, int n_pix);
    return (cnt >= n_pix) ? 1 : cnt + 1;
  endfunction

endpackage

// File: rtl/lsr_pixel_counter.sv
`timescale 1ns/1ps
module lsr_pixel_counter
  import lsr_pkg::*;
#(
  parameter int NUM_PIX = 64,
  parameter int IDX_W   = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output seq_state_e       state,
  output logic [IDX_W-1:0] cnt,
  output logic             fresh,
  output logic             restart_ev,
  output logic             new_start_ev,
  output logic             release_ev
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX);
  localparam logic [IDX_W-1:0] PEN_IDX  = IDX_W'(NUM_PIX - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  always_comb begin
    restart_ev   = is_restart(start, state, int'(cnt), NUM_PIX);
    new_start_ev = start && !restart_ev;
    release_ev   = !start && (state == SEQ_READ) && (cnt == PEN_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (start) begin
      state <= SEQ_READ;
      cnt   <= ONE_IDX;
      fresh <= new_start_ev;
    end else begin
      case (state)
        SEQ_READ: begin
          if (cnt == LAST_IDX) begin
            state <= SEQ_TRACK;
            fresh <= 1'b0;
          end
          cnt <= IDX_W'(next_count(int'(cnt), NUM_PIX));
        end
        SEQ_TRACK: begin
          cnt <= ONE_IDX;
        end
        default: begin
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsr_hold_ctrl.sv
`timescale 1ns/1ps
module lsr_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic new_start_ev,
  input  logic release_ev,
  output logic hold_main,
  output logic hold_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_main <= 1'b0;
    end else if (new_start_ev) begin
      hold_main <= 1'b1;
    end else if (release_ev) begin
      hold_main <= 1'b0;
    end
  end

  // Pixel 64 trails the shared line by one clock in both directions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_last <= 1'b0;
    end else begin
      hold_last <= hold_main;
    end
  end

endmodule

// File: rtl/lsr_integ_pulse.sv
`timescale 1ns/1ps
module lsr_integ_pulse
  import lsr_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int PULSE_AT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state,
  input  logic [IDX_W-1:0] cnt,
  input  logic             fresh,
  output logic             fire,
  output logic             integ_rst_n
);

  localparam logic [IDX_W-1:0] FIRE_IDX = IDX_W'(PULSE_AT);

  assign fire = fresh && (state == SEQ_READ) && (cnt == FIRE_IDX);

  // Falling-edge register: output is a clean full-clock low pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_rst_n <= 1'b0;
    end else begin
      integ_rst_n <= !fire;
    end
  end

endmodule

// File: rtl/lsr_readout_seq.sv
`timescale 1ns/1ps
module lsr_readout_seq
  import lsr_pkg::*;
#(
  parameter int NUM_PIX = 64,
  parameter int IDX_W   = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [IDX_W-1:0] pix_idx,
  output logic             pix_valid,
  output logic             hold_main,
  output logic             hold_last,
  output logic             integ_rst_n
);

  localparam int PULSE_AT = 2;

  seq_state_e       state;
  logic [IDX_W-1:0] cnt;
  logic             fresh;
  logic             restart_ev;
  logic             new_start_ev;
  logic             release_ev;
  logic             integ_fire;

  lsr_pixel_counter #(
    .NUM_PIX (NUM_PIX),
    .IDX_W   (IDX_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .state        (state),
    .cnt          (cnt),
    .fresh        (fresh),
    .restart_ev   (restart_ev),
    .new_start_ev (new_start_ev),
    .release_ev   (release_ev)
  );

  lsr_hold_ctrl u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .new_start_ev (new_start_ev),
    .release_ev   (release_ev),
    .hold_main    (hold_main),
    .hold_last    (hold_last)
  );

  lsr_integ_pulse #(
    .IDX_W    (IDX_W),
    .PULSE_AT (PULSE_AT)
  ) u_integ (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .cnt         (cnt),
    .fresh       (fresh),
    .fire        (integ_fire),
    .integ_rst_n (integ_rst_n)
  );

  assign pix_idx   = IDX_W'(shown_index(state, int'(cnt)));
  assign pix_valid = (state == SEQ_READ);

endmodule

// File: rtl/lsr_readout_seq_chk.sv
`timescale 1ns/1ps
module lsr_readout_seq_chk #(
  parameter int NUM_PIX = 64,
  parameter int IDX_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] pix_idx,
  input logic             pix_valid,
  input logic             hold_main,
  input logic             hold_last,
  input logic             integ_rst_n,
  input logic             restart_ev,
  input logic             new_start_ev
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX);
  localparam logic [IDX_W-1:0] PEN_IDX  = IDX_W'(NUM_PIX - 1);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (pix_idx == '0 && !pix_valid && !hold_main && !hold_last); // R1
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx < LAST_IDX && !start) |=> (pix_idx == $past(pix_idx) + 1'b1)); // R2
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pix_valid && pix_idx == IDX_W'(1))); // R2
  AST_LAST_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hold_last == $past(hold_main))); // R3
  AST_FRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    new_start_ev |=> (hold_main && !hold_last)); // R3
  AST_MAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx == PEN_IDX && !start) |=> !hold_main); // R4
  AST_CLEAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_rst_n) |-> (pix_valid && pix_idx == IDX_W'(2))); // R5
  AST_CLEAR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_rst_n) |=> integ_rst_n); // R5
  AST_RESTART_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> (hold_main && hold_last)); // R6
  AST_TRACK_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && pix_idx != '0) |-> !hold_main); // R8
  AST_VALID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_idx != '0 && pix_idx <= LAST_IDX)); // R10

endmodule

bind lsr_readout_seq lsr_readout_seq_chk #(
  .NUM_PIX (NUM_PIX),
  .IDX_W   (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .pix_idx      (pix_idx),
  .pix_valid    (pix_valid),
  .hold_main    (hold_main),
  .hold_last    (hold_last),
  .integ_rst_n  (integ_rst_n),
  .restart_ev   (restart_ev),
  .new_start_ev (new_start_ev)
);

// File: tb/lsr_readout_seq_test.sv
`timescale 1ns/1ps
module lsr_readout_seq_test;

  localparam int N = 64;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] pix_idx;
  logic         pix_valid;
  logic         hold_main;
  logic         hold_last;
  logic         integ_rst_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state: 0 idle, 1 reading, 2 tracking.
  int m_st = 0;
  int m_cnt = 0;
  int m_hm = 0;
  int m_hl = 0;
  int m_fresh = 0;

  always #5 clk = ~clk;

  lsr_readout_seq #(.NUM_PIX(N)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pix_idx     (pix_idx),
    .pix_valid   (pix_valid),
    .hold_main   (hold_main),
    .hold_last   (hold_last),
    .integ_rst_n (integ_rst_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One readout clock with start = s; compares every output after the edge.
  task automatic step(input bit s, input string tag);
    int exp_int;
    int exp_idx;
    exp_int = (m_st == 1 && m_cnt == 2 && m_fresh == 1) ? 0 : 1;
    m_hl = m_hm;
    if (s) begin
      if (m_st == 1 && m_cnt < N) begin
        m_fresh = 0;
      end else begin
        m_fresh = 1;
        m_hm = 1;
      end
      m_st = 1;
      m_cnt = 1;
    end else if (m_st == 1) begin
      if (m_cnt == N - 1) m_hm = 0;
      if (m_cnt == N) begin
        m_st = 2;
        m_fresh = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    exp_idx = (m_st == 1) ? m_cnt : ((m_st == 2) ? 1 : 0);
    start = s;
    @(posedge clk);
    #2;
    chk(tag, "pix_idx", int'(pix_idx), exp_idx);
    chk(tag, "pix_valid R10", int'(pix_valid), (m_st == 1) ? 1 : 0);
    chk(tag, "hold_main R3/R4", int'(hold_main), m_hm);
    chk(tag, "hold_last R3/R4", int'(hold_last), m_hl);
    chk(tag, "integ_rst_n R5", int'(integ_rst_n), exp_int);
  endtask

  initial begin
    // R1 and R9: outputs quiet in reset even with start held high.
    start = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "pix_idx", int'(pix_idx), 0);
    chk("R1", "pix_valid", int'(pix_valid), 0);
    chk("R1", "hold_main", int'(hold_main), 0);
    chk("R1", "hold_last", int'(hold_last), 0);
    chk("R1", "integ_rst_n", int'(integ_rst_n), 0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (3) step(1'b0, "R9");

    // Full readout into tracking.
    step(1'b1, "R2");
    repeat (N + 4) step(1'b0, "R2 R3 R4 R5 R8 R10");

    // Second start at every index; 64 is the fresh-start boundary.
    for (int k = 1; k <= N; k++) begin
      step(1'b1, "R2");
      while (m_cnt != k) step(1'b0, "R2");
      step(1'b1, (k < N) ? "R6" : "R7");
      repeat (5) step(1'b0, (k < N) ? "R6" : "R7");
      while (m_st != 2) step(1'b0, "R4");
      repeat (3) step(1'b0, "R8");
    end

    // Starts on consecutive clocks, then a restart inside the clear window.
    repeat (4) step(1'b1, "R6");
    repeat (N + 3) step(1'b0, "R8");
    step(1'b1, "R5");
    step(1'b0, "R5");
    step(1'b1, "R6");
    repeat (N + 3) step(1'b0, "R8");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule